// File: doc/BRIEF.md
# Auxiliary channel pixel formatter

This block sits between an auxiliary data channel and the two operand pipes, source and pattern, that feed a raster operation datapath. Raw 32-bit words fetched for the channel arrive on a valid/ready input. The formatter turns each word into one or more output beats and drives them onto whichever operand pipe has been selected. The pipe that is not selected passes through unchanged. When the channel is disabled, both pipes pass straight through and the channel input is never accepted.

Each channel word is treated as colour or as alpha. A colour word leaves as a single beat. When the red/blue reorder control is set, the colour fields are exchanged according to the output depth. An alpha word holds four 8-bit alpha values. For a 32-bpp output, each value leaves on its own beat. For a 16-bpp output, the values are cut down to their upper nibble and leave in pairs. The combination of alpha input and an 8-bpp output has no meaning. That combination raises an error flag and stops the channel.

Configuration is static while words are in flight. Output backpressure is honoured, and a new word is taken in the same cycle that the last beat of the previous word leaves.

Top module: `aux_pix_fmt`

## Requirements
- R1: With cfg_en_i = 0, src_*_o equal src_*_i, pat_*_o equal pat_*_i, each ready output equals the matching ready input, and ch_ready_o = 0.
- R2: With cfg_en_i = 1 and cfg_pipe_sel_i = 0, channel beats drive the pattern output, pat_ready_o = 0, and the source pipe passes through as in R1.
- R3: With cfg_en_i = 1 and cfg_pipe_sel_i = 1, channel beats drive the source output, src_ready_o = 0, and the pattern pipe passes through.
- R4: In colour mode (cfg_alpha_i = 0), each accepted word yields exactly one beat. With cfg_swap_i = 0 the beat equals the word.
- R5: In colour mode with cfg_swap_i = 1 and a 32-bpp depth (cfg_depth_i[1] = 1), bits [7:0] and [23:16] are exchanged and the other bits are kept. At an 8-bpp depth (cfg_depth_i = 00) the word is unchanged.
- R6: In colour mode with cfg_swap_i = 1 and a 16-bpp depth (cfg_depth_i = 01), each 16-bit half has its bits [4:0] and [15:11] exchanged, with bits [10:5] kept.
- R7: cfg_swap_i has no effect on alpha words.
- R8: Alpha at a 32-bpp depth yields four beats per word. Beat k carries word bits [8k+7:8k] in bits [7:0], and zero in the rest.
- R9: Alpha at a 16-bpp depth yields two beats per word. Beat k carries word bits [16k+7:16k+4] in bits [3:0] and word bits [16k+15:16k+12] in bits [7:4], and zero in the rest.
- R10: Alpha with cfg_depth_i = 00 drives cfg_err_o = 1 and ch_ready_o = 0, and produces no beat on the selected pipe.
- R11: While a formatted beat is valid and not accepted, it stays valid and unchanged. With the output always ready, colour words are taken one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Channel enable |
| cfg_pipe_sel_i | input | 1 | 0: replace pattern pipe, 1: replace source pipe |
| cfg_swap_i | input | 1 | Red/blue field reorder |
| cfg_alpha_i | input | 1 | Channel words hold alpha |
| cfg_depth_i | input | 2 | Output depth: 00 8 bpp, 01 16 bpp, 1x 32 bpp |
| ch_valid_i | input | 1 | Channel word valid |
| ch_data_i | input | DATA_W | Channel word |
| ch_ready_o | output | 1 | Channel word accepted |
| src_valid_i | input | 1 | Upstream source valid |
| src_data_i | input | DATA_W | Upstream source data |
| src_ready_o | output | 1 | Upstream source ready |
| pat_valid_i | input | 1 | Upstream pattern valid |
| pat_data_i | input | DATA_W | Upstream pattern data |
| pat_ready_o | output | 1 | Upstream pattern ready |
| src_valid_o | output | 1 | Source operand valid |
| src_data_o | output | DATA_W | Source operand data |
| src_ready_i | input | 1 | Source operand ready |
| pat_valid_o | output | 1 | Pattern operand valid |
| pat_data_o | output | DATA_W | Pattern operand data |
| pat_ready_i | input | 1 | Pattern operand ready |
| cfg_err_o | output | 1 | Alpha requested at 8 bpp |

## Verification
The checker tests several properties on every cycle. It checks the pass-through and blocking of the pipes for each enable and pipe-select setting. It checks the error response to alpha at 8 bpp. It checks that a stalled beat on the pattern pipe stays valid and unchanged, and that 16-bpp alpha beats keep their upper bits at zero.

Other properties can only be shown by the bench's scenarios. These are the beat count and order for each word and the field exchanges for each depth. They also include swap having no effect on alpha, and a sustained colour rate of one word per clock. The scoreboard checks these against values it computes itself, with the output ready held high and with it toggled by a pseudo-random pattern.

// File: rtl/aux_pix_pkg.sv
package aux_pix_pkg;
  typedef enum logic [1:0] {
    DEPTH_8  = 2'b00,
    DEPTH_16 = 2'b01,
    DEPTH_32 = 2'b10
  } depth_e;

  function automatic logic is_d32(input logic [1:0] d);
    return d[1];
  endfunction

  function automatic logic is_d16(input logic [1:0] d);
    return d == DEPTH_16;
  endfunction

  function automatic logic is_d8(input logic [1:0] d);
    return d == DEPTH_8;
  endfunction
endpackage

// File: rtl/aux_rgb_swap.sv
module aux_rgb_swap #(
  parameter int DATA_W = 32
) (
  input  logic              swap_i,
  input  logic [1:0]        depth_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  import aux_pix_pkg::*;

  localparam int L32 = DATA_W / 32;
  localparam int L16 = DATA_W / 16;

  logic [DATA_W-1:0] sw32, sw16;

  for (genvar g = 0; g < L32; g++) begin : g_l32
    assign sw32[g*32 +: 32] = {d_i[g*32+24 +: 8], d_i[g*32 +: 8],
                               d_i[g*32+8 +: 8],  d_i[g*32+16 +: 8]};
  end

  for (genvar g = 0; g < L16; g++) begin : g_l16
    assign sw16[g*16 +: 16] = {d_i[g*16 +: 5], d_i[g*16+5 +: 6], d_i[g*16+11 +: 5]};
  end

  always_comb begin
    q_o = d_i;
    if (swap_i) begin
      if (is_d32(depth_i))      q_o = sw32;
      else if (is_d16(depth_i)) q_o = sw16;
    end
  end
endmodule

// File: rtl/aux_word_unpack.sv
module aux_word_unpack #(
  parameter int DATA_W  = 32,
  parameter int ALPHA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              alpha_i,
  input  logic [1:0]        depth_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              err_o
);
  import aux_pix_pkg::*;

  localparam int NA    = DATA_W / ALPHA_W;
  localparam int IDX_W = (NA > 1) ? $clog2(NA) : 1;
  localparam int HALF  = ALPHA_W / 2;

  logic              hold_vld;
  logic [DATA_W-1:0] hold;
  logic [IDX_W-1:0]  idx, last_idx;
  logic              last, fire_in, fire_out;

  assign err_o = en_i && alpha_i && is_d8(depth_i);

  always_comb begin
    if (!alpha_i)             last_idx = '0;
    else if (is_d32(depth_i)) last_idx = IDX_W'(NA - 1);
    else                      last_idx = IDX_W'(NA / 2 - 1);
  end

  assign last        = (idx == last_idx);
  assign out_valid_o = hold_vld && !err_o;
  assign fire_out    = out_valid_o && out_ready_i;
  // Refill in the same cycle as the last beat leaves: no bubble
  assign in_ready_o  = en_i && !err_o && (!hold_vld || (out_ready_i && last));
  assign fire_in     = in_valid_i && in_ready_o;

  always_comb begin
    out_data_o = '0;
    if (!alpha_i) begin
      out_data_o = hold;
    end else if (is_d32(depth_i)) begin
      out_data_o[ALPHA_W-1:0] = hold[idx*ALPHA_W +: ALPHA_W];
    end else begin
      out_data_o[HALF-1:0]       = hold[(2*idx)*ALPHA_W + HALF +: HALF];
      out_data_o[ALPHA_W-1:HALF] = hold[(2*idx+1)*ALPHA_W + HALF +: HALF];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld <= 1'b0;
      hold     <= '0;
      idx      <= '0;
    end else if (!en_i) begin
      hold_vld <= 1'b0;
      idx      <= '0;
    end else if (fire_in) begin
      hold_vld <= 1'b1;
      hold     <= in_data_i;
      idx      <= '0;
    end else if (fire_out) begin
      if (last) hold_vld <= 1'b0;
      else      idx      <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/aux_pipe_route.sv
module aux_pipe_route #(
  parameter int DATA_W = 32
) (
  input  logic              en_i,
  input  logic              sel_i,
  input  logic              fmt_valid_i,
  input  logic [DATA_W-1:0] fmt_data_i,
  output logic              fmt_ready_o,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  input  logic              pat_valid_i,
  input  logic [DATA_W-1:0] pat_data_i,
  output logic              pat_ready_o,
  output logic              src_valid_o,
  output logic [DATA_W-1:0] src_data_o,
  input  logic              src_ready_i,
  output logic              pat_valid_o,
  output logic [DATA_W-1:0] pat_data_o,
  input  logic              pat_ready_i
);
  logic rep_src, rep_pat;

  assign rep_src = en_i && sel_i;
  assign rep_pat = en_i && !sel_i;

  assign src_valid_o = rep_src ? fmt_valid_i : src_valid_i;
  assign src_data_o  = rep_src ? fmt_data_i  : src_data_i;
  assign src_ready_o = rep_src ? 1'b0        : src_ready_i;

  assign pat_valid_o = rep_pat ? fmt_valid_i : pat_valid_i;
  assign pat_data_o  = rep_pat ? fmt_data_i  : pat_data_i;
  assign pat_ready_o = rep_pat ? 1'b0        : pat_ready_i;

  assign fmt_ready_o = sel_i ? src_ready_i : pat_ready_i;
endmodule

// File: rtl/aux_pix_fmt.sv
module aux_pix_fmt #(
  parameter int DATA_W  = 32,
  parameter int ALPHA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_pipe_sel_i,
  input  logic              cfg_swap_i,
  input  logic              cfg_alpha_i,
  input  logic [1:0]        cfg_depth_i,
  input  logic              ch_valid_i,
  input  logic [DATA_W-1:0] ch_data_i,
  output logic              ch_ready_o,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  input  logic              pat_valid_i,
  input  logic [DATA_W-1:0] pat_data_i,
  output logic              pat_ready_o,
  output logic              src_valid_o,
  output logic [DATA_W-1:0] src_data_o,
  input  logic              src_ready_i,
  output logic              pat_valid_o,
  output logic [DATA_W-1:0] pat_data_o,
  input  logic              pat_ready_i,
  output logic              cfg_err_o
);
  logic [DATA_W-1:0] swapped, fmt_data;
  logic              fmt_valid, fmt_ready;

  // Alpha words are never reordered
  aux_rgb_swap #(.DATA_W(DATA_W)) u_swap (
    .swap_i  (cfg_swap_i && !cfg_alpha_i),
    .depth_i (cfg_depth_i),
    .d_i     (ch_data_i),
    .q_o     (swapped)
  );

  aux_word_unpack #(.DATA_W(DATA_W), .ALPHA_W(ALPHA_W)) u_unpack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cfg_en_i),
    .alpha_i     (cfg_alpha_i),
    .depth_i     (cfg_depth_i),
    .in_valid_i  (ch_valid_i),
    .in_data_i   (swapped),
    .in_ready_o  (ch_ready_o),
    .out_valid_o (fmt_valid),
    .out_data_o  (fmt_data),
    .out_ready_i (fmt_ready),
    .err_o       (cfg_err_o)
  );

  aux_pipe_route #(.DATA_W(DATA_W)) u_route (
    .en_i        (cfg_en_i),
    .sel_i       (cfg_pipe_sel_i),
    .fmt_valid_i (fmt_valid),
    .fmt_data_i  (fmt_data),
    .fmt_ready_o (fmt_ready),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_ready_o (src_ready_o),
    .pat_valid_i (pat_valid_i),
    .pat_data_i  (pat_data_i),
    .pat_ready_o (pat_ready_o),
    .src_valid_o (src_valid_o),
    .src_data_o  (src_data_o),
    .src_ready_i (src_ready_i),
    .pat_valid_o (pat_valid_o),
    .pat_data_o  (pat_data_o),
    .pat_ready_i (pat_ready_i)
  );
endmodule

// File: rtl/aux_pix_fmt_chk.sv
module aux_pix_fmt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_en_i,
  input logic              cfg_pipe_sel_i,
  input logic              cfg_alpha_i,
  input logic [1:0]        cfg_depth_i,
  input logic              ch_ready_o,
  input logic              src_valid_i,
  input logic [DATA_W-1:0] src_data_i,
  input logic              src_ready_o,
  input logic              pat_valid_i,
  input logic [DATA_W-1:0] pat_data_i,
  input logic              pat_ready_o,
  input logic              src_valid_o,
  input logic [DATA_W-1:0] src_data_o,
  input logic              src_ready_i,
  input logic              pat_valid_o,
  input logic [DATA_W-1:0] pat_data_o,
  input logic              pat_ready_i,
  input logic              cfg_err_o
);
  a_r1_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |-> (src_data_o == src_data_i) && (src_valid_o == src_valid_i) &&
                  (pat_data_o == pat_data_i) && (pat_valid_o == pat_valid_i) &&
                  (src_ready_o == src_ready_i) && (pat_ready_o == pat_ready_i) && !ch_ready_o);

  a_r2_pat_replaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && !cfg_pipe_sel_i) |-> !pat_ready_o && (src_data_o == src_data_i) &&
                                      (src_valid_o == src_valid_i) && (src_ready_o == src_ready_i));

  a_r3_src_replaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && cfg_pipe_sel_i) |-> !src_ready_o && (pat_data_o == pat_data_i) &&
                                     (pat_valid_o == pat_valid_i) && (pat_ready_o == pat_ready_i));

  a_r9_alpha16_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && !cfg_pipe_sel_i && cfg_alpha_i && cfg_depth_i == 2'b01 && pat_valid_o)
      |-> (pat_data_o[DATA_W-1:8] == '0));

  a_r10_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && cfg_alpha_i && cfg_depth_i == 2'b00) |-> cfg_err_o && !ch_ready_o);

  a_r10_no_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && !cfg_pipe_sel_i && cfg_alpha_i && cfg_depth_i == 2'b00) |-> !pat_valid_o);

  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && !cfg_pipe_sel_i && pat_valid_o && !pat_ready_i)
      |=> pat_valid_o && $stable(pat_data_o));
endmodule

bind aux_pix_fmt aux_pix_fmt_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/aux_pix_fmt_tb.sv
module aux_pix_fmt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 50000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_en_i, cfg_pipe_sel_i, cfg_swap_i, cfg_alpha_i;
  logic [1:0]  cfg_depth_i;
  logic        ch_valid_i;
  logic [31:0] ch_data_i;
  logic        ch_ready_o;
  logic        src_valid_i, pat_valid_i;
  logic [31:0] src_data_i, pat_data_i;
  logic        src_ready_o, pat_ready_o;
  logic        src_valid_o, pat_valid_o;
  logic [31:0] src_data_o, pat_data_o;
  logic        src_ready_i, pat_ready_i;
  logic        cfg_err_o;

  logic        stall_on = 1'b0;
  logic        base_src_rdy, base_pat_rdy;
  logic [7:0]  lfsr = 8'hA7;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        st_pend = 1'b0;
  logic [31:0] st_data;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign src_ready_i = stall_on ? lfsr[0] : base_src_rdy;
  assign pat_ready_i = stall_on ? lfsr[3] : base_pat_rdy;

  aux_pix_fmt u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_en_i(cfg_en_i), .cfg_pipe_sel_i(cfg_pipe_sel_i), .cfg_swap_i(cfg_swap_i),
    .cfg_alpha_i(cfg_alpha_i), .cfg_depth_i(cfg_depth_i),
    .ch_valid_i(ch_valid_i), .ch_data_i(ch_data_i), .ch_ready_o(ch_ready_o),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_ready_o(src_ready_o),
    .pat_valid_i(pat_valid_i), .pat_data_i(pat_data_i), .pat_ready_o(pat_ready_o),
    .src_valid_o(src_valid_o), .src_data_o(src_data_o), .src_ready_i(src_ready_i),
    .pat_valid_o(pat_valid_o), .pat_data_o(pat_data_o), .pat_ready_i(pat_ready_i),
    .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always begin
    @(posedge clk_i);
    cyc++;
    #1 lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (cyc > WDOG) begin
      chk(1'b0, "watchdog", cyc, WDOG);
      finish_run();
    end
  end

  // Monitor: compare beats on the replaced pipe with the scoreboard
  always @(negedge clk_i) begin
    logic v, r;
    logic [31:0] d;
    if (rst_ni && cfg_en_i) begin
      v = cfg_pipe_sel_i ? src_valid_o : pat_valid_o;
      r = cfg_pipe_sel_i ? src_ready_i : pat_ready_i;
      d = cfg_pipe_sel_i ? src_data_o  : pat_data_o;
      if (st_pend) begin
        chk(v && d == st_data, "R11 stalled beat held", d, st_data);
        st_pend = 1'b0;
      end
      if (v && !r) begin
        st_pend = 1'b1;
        st_data = d;
      end
      if (v && r) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected beat", d, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(d == e, t, d, e);
        end
      end
    end else st_pend = 1'b0;
  end

  function automatic logic [31:0] m_sw32(input logic [31:0] d);
    return {d[31:24], d[7:0], d[15:8], d[23:16]};
  endfunction

  function automatic logic [15:0] m_sw16(input logic [15:0] h);
    return {h[4:0], h[10:5], h[15:11]};
  endfunction

  task automatic push(input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Called just after a posedge; returns just after the accepting posedge
  task automatic send_word(input logic [31:0] d);
    if (cfg_alpha_i) begin
      if (cfg_depth_i[1]) begin
        for (int k = 0; k < 4; k++)
          push({24'h0, d[8*k +: 8]}, cfg_swap_i ? "R7 alpha32 unswapped" : "R8 alpha32 beat");
      end else begin
        for (int k = 0; k < 2; k++)
          push({24'h0, d[16*k+12 +: 4], d[16*k+4 +: 4]}, "R9 alpha16 beat");
      end
    end else if (!cfg_swap_i || cfg_depth_i == 2'b00) begin
      push(d, cfg_swap_i ? "R5 8bpp swap no-op" : "R4 colour beat");
    end else if (cfg_depth_i[1]) begin
      push(m_sw32(d), "R5 swap32");
    end else begin
      push({m_sw16(d[31:16]), m_sw16(d[15:0])}, "R6 swap16");
    end
    ch_valid_i = 1'b1;
    ch_data_i  = d;
    do @(negedge clk_i); while (!ch_ready_o);
    @(posedge clk_i);
    #1;
  endtask

  task automatic end_burst();
    ch_valid_i = 1'b0;
  endtask

  task automatic drain(input string t);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(posedge clk_i);
    @(posedge clk_i);
    #1;
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
  endtask

  task automatic set_cfg(input logic en, input logic ps, input logic sw, input logic al, input logic [1:0] dp);
    @(posedge clk_i);
    #1;
    cfg_en_i = en; cfg_pipe_sel_i = ps; cfg_swap_i = sw; cfg_alpha_i = al; cfg_depth_i = dp;
  endtask

  initial begin
    int t0;
    rst_ni = 1'b0;
    cfg_en_i = 0; cfg_pipe_sel_i = 0; cfg_swap_i = 0; cfg_alpha_i = 0; cfg_depth_i = 2'b10;
    ch_valid_i = 0; ch_data_i = '0;
    src_valid_i = 0; src_data_i = '0; pat_valid_i = 0; pat_data_i = '0;
    base_src_rdy = 1'b1; base_pat_rdy = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!ch_ready_o && !cfg_err_o, "R1 reset state", {30'h0, ch_ready_o, cfg_err_o}, 0);
    rst_ni = 1'b1;

    // R1 bypass
    @(posedge clk_i); #1;
    src_valid_i = 1; src_data_i = 32'hA5A5_0001; pat_valid_i = 1; pat_data_i = 32'h5A5A_0002;
    base_src_rdy = 1'b1; base_pat_rdy = 1'b0;
    @(negedge clk_i);
    chk(src_valid_o && src_data_o == src_data_i && src_ready_o, "R1 src bypass", src_data_o, src_data_i);
    chk(pat_valid_o && pat_data_o == pat_data_i && !pat_ready_o && !ch_ready_o, "R1 pat bypass", pat_data_o, pat_data_i);

    // R2 pattern replaced
    set_cfg(1, 0, 0, 0, 2'b10);
    @(negedge clk_i);
    chk(src_valid_o && src_data_o == src_data_i && src_ready_o, "R2 src passes", src_data_o, src_data_i);
    chk(!pat_valid_o && !pat_ready_o, "R2 pat blocked", {pat_valid_o, pat_ready_o}, 0);
    @(posedge clk_i); #1;
    src_valid_i = 0; pat_valid_i = 0; base_pat_rdy = 1'b1;

    // R4 + R11 rate: four colour words in four cycles
    t0 = cyc;
    send_word(32'h1122_3344); send_word(32'hDEAD_BEEF);
    send_word(32'h0000_0000); send_word(32'hFFFF_FFFF);
    chk(cyc - t0 == 4, "R11 one word per clock", cyc - t0, 4);
    end_burst();
    drain("R4 colour drain");

    // R5 swap32
    set_cfg(1, 0, 1, 0, 2'b10);
    send_word(32'h1122_3344); send_word(32'hA1B2_C3D4); send_word(32'h00FF_0F0F);
    end_burst();
    drain("R5 swap32 drain");

    // R6 swap16, R5 8bpp
    set_cfg(1, 0, 1, 0, 2'b01);
    send_word(32'hF800_001F); send_word(32'h1234_ABCD);
    end_burst();
    drain("R6 swap16 drain");
    set_cfg(1, 0, 1, 0, 2'b00);
    send_word(32'h1234_5678);
    end_burst();
    drain("R5 8bpp drain");

    // R3 source replaced
    set_cfg(1, 1, 0, 0, 2'b10);
    pat_valid_i = 1; pat_data_i = 32'h0BAD_F00D; src_valid_i = 1; src_data_i = 32'h1;
    base_pat_rdy = 1'b0;
    @(negedge clk_i);
    chk(pat_valid_o && pat_data_o == pat_data_i && !pat_ready_o, "R3 pat passes", pat_data_o, pat_data_i);
    chk(!src_ready_o && !src_valid_o, "R3 src blocked", {src_ready_o, src_valid_o}, 0);
    @(posedge clk_i); #1;
    send_word(32'hCAFE_0001); send_word(32'hCAFE_0002);
    end_burst();
    drain("R3 source drain");
    pat_valid_i = 0; src_valid_i = 0; base_pat_rdy = 1'b1;

    // R8 alpha32 with swap set (R7)
    set_cfg(1, 0, 1, 1, 2'b10);
    send_word(32'h4433_2211); send_word(32'hF0E1_D2C3);
    end_burst();
    drain("R8 alpha32 drain");

    // R9 alpha16
    set_cfg(1, 0, 0, 1, 2'b01);
    send_word(32'h9F8E_7D6C); send_word(32'h1A2B_3C4D);
    end_burst();
    drain("R9 alpha16 drain");

    // R11 random backpressure across modes
    stall_on = 1'b1;
    send_word(32'hABCD_1234); send_word(32'h5566_7788);
    end_burst();
    drain("R11 stall alpha16 drain");
    set_cfg(1, 0, 0, 1, 2'b10);
    send_word(32'h0102_0304); send_word(32'hFEDC_BA98);
    end_burst();
    drain("R11 stall alpha32 drain");
    set_cfg(1, 0, 1, 0, 2'b10);
    for (int i = 0; i < 6; i++) send_word(32'h1357_9BDF + 32'(i * 32'h0101_0101));
    end_burst();
    drain("R11 stall colour drain");
    stall_on = 1'b0;

    // R10 alpha at 8 bpp
    set_cfg(1, 0, 0, 1, 2'b00);
    ch_valid_i = 1; ch_data_i = 32'h7777_7777;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(cfg_err_o && !ch_ready_o && !pat_valid_o, "R10 error blocks",
          {29'h0, cfg_err_o, ch_ready_o, pat_valid_o}, 32'h4);
    end
    @(posedge clk_i); #1;
    ch_valid_i = 0;
    set_cfg(1, 0, 0, 0, 2'b00);
    @(negedge clk_i);
    chk(!cfg_err_o && ch_ready_o, "R10 error clears", {cfg_err_o, ch_ready_o}, 1);
    chk(exp_q.size() == 0, "R10 no beat produced", exp_q.size(), 0);

    finish_run();
  end
endmodule